// File: doc/BRIEF.md
# PCM Time-Slot Assigner

This block sits between the per-channel sample path of a multi-channel voice codec and a serial PCM highway. Each channel owns a programmable time slot. In that slot it shifts a transmit sample out on transmit port A, port B, or both. In the same slot it captures a receive sample from receive port A or port B. The block runs directly on the PCM bit clock, so one clock cycle carries one highway bit. An 8 kHz frame sync marks the start of each frame. The frame holds `SLOTS` slots of eight bits each.

A channel moves either one byte per frame (compressed, 8-bit) or two back-to-back bytes (linear, 16-bit). A linear channel occupies its programmed slot and the slot after it. Transmit samples are taken once per frame, at frame sync, so the sample feeding a slot cannot change mid-burst. Each received sample is handed over with a one-cycle valid strobe.

The transmit ports are modelled as a data bit plus an output enable, and the enable is low wherever the port would float. Two checks on the configuration are reported as flags. The first is a linear channel placed in the last slot. The second is two channels overlapping on the same transmit port. When channels overlap, the lowest-numbered channel keeps the port.

Top module: `pcm_tsa`

## Requirements
- R1: Reset clears the bit counter. A frame sync sampled high at a rising edge makes the following cycle bit 0 of slot 0. The bit position then advances by one per clock and wraps to 0 after `SLOTS*8` bits, even without a new frame sync.
- R2: An active channel with slot number s transmits during bit positions 8s to 8s+7 in compressed mode, sending `tx_sample[7:0]`. In linear mode it transmits during bit positions 8s to 8s+15, sending `tx_sample[15:0]`. Data goes out MSB first, one bit per clock.
- R3: The transmit select bits pick the ports: `cfg_tx_a` routes the channel to port A and `cfg_tx_b` routes it to port B. With both set, both ports carry the same bits.
- R4: A port's output enable is high only during bit positions claimed by an active channel routed to it. The enable is low when the channel is disabled or its cutoff bit is set. While the enable is low, the data output is 0.
- R5: The transmit sample of every channel is captured at the rising edge where frame sync is high. Changes to `tx_sample` at any other time do not affect the bits sent in that frame.
- R6: An active channel shifts in one bit per clock during its burst. The source is port A when `cfg_rx_b`=0 and port B when `cfg_rx_b`=1. One cycle after the edge that samples the final bit, `rx_valid` pulses high for one cycle. At that point `rx_data` holds the sample MSB-first: all 16 bits in linear mode, or the bits in [7:0] with [15:8]=0 in compressed mode. `rx_data` holds its value until the next delivery.
- R7: `cfg_err[ch]` is high while the channel is enabled, linear, and programmed to slot `SLOTS-1`. Such a channel neither transmits nor receives.
- R8: When several channels claim the same bit on one port, the lowest-numbered channel drives it. `conflict_a` or `conflict_b` is high while the burst ranges of two active, non-cutoff channels routed to that port overlap.
- R9: After reset, both output enables are low, `rx_valid` is 0, `rx_data` is 0, and the held transmit samples are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fs | input | 1 | Frame sync, one cycle wide, marks bit 0 of slot 0 |
| cfg_en | input | NCH | Channel enable |
| cfg_slot | input | NCH*SLOT_W | Slot number per channel, channel ch in bits [ch*SLOT_W +: SLOT_W] |
| cfg_tx_a | input | NCH | Route channel to transmit port A |
| cfg_tx_b | input | NCH | Route channel to transmit port B |
| cfg_rx_b | input | NCH | Receive from port B (1) or port A (0) |
| cfg_lin | input | NCH | 16-bit linear (1) or 8-bit compressed (0) |
| cfg_cut | input | NCH | Transmit cutoff |
| tx_sample | input | NCH*16 | Transmit sample per channel, channel ch in bits [ch*16 +: 16] |
| rx_a | input | 1 | Receive port A serial data |
| rx_b | input | 1 | Receive port B serial data |
| tx_a_d | output | 1 | Transmit port A data |
| tx_a_oe | output | 1 | Transmit port A output enable |
| tx_b_d | output | 1 | Transmit port B data |
| tx_b_oe | output | 1 | Transmit port B output enable |
| rx_data | output | NCH*16 | Received sample per channel |
| rx_valid | output | NCH | One-cycle strobe per channel on a new sample |
| cfg_err | output | NCH | Linear channel placed in the last slot |
| conflict_a | output | 1 | Overlapping claims on port A |
| conflict_b | output | 1 | Overlapping claims on port B |

## Verification
The transmit data and enables are combinational from the registered bit counter and held samples. The bit for frame position k therefore appears in the (k+1)-th cycle after the edge that samples frame sync. The flags react to the configuration within the same cycle. A received sample shows up on `rx_valid`/`rx_data` in the cycle after the edge that samples its final bit. The bench changes its inputs just after the falling edge. It advances a behavioural model at each rising edge and compares every output at the next falling edge, so each result is read in the cycle it is due. The transmit sample and the receive lines are randomised every cycle, which exposes any sampling outside frame sync or outside the owned bits.

// File: rtl/tsa_pkg.sv
// Shared constants for the PCM time-slot assigner.
// Assumes: eight bits per slot, samples carried in a 16-bit container.
package tsa_pkg;
    localparam int SLOT_BITS = 8;
    localparam int SAMPLE_W  = 16;
endpackage

// File: rtl/tsa_frame_counter.sv
// Frame bit counter: position of the current highway bit inside the frame.
// Assumes: fs is synchronous to clk and one cycle wide; the frame is SLOTS*8 bits.
module tsa_frame_counter #(
    parameter int SLOTS = 32,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs,
    output logic [CNT_W-1:0] bit_cnt
);
    localparam int FRAME_BITS = SLOTS * tsa_pkg::SLOT_BITS;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    // Restart on frame sync, otherwise count and wrap at end of frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_cnt <= '0;
        else if (fs || bit_cnt == LAST)
            bit_cnt <= '0;
        else
            bit_cnt <= bit_cnt + CNT_W'(1);
    end

    // R1
    fs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs |=> bit_cnt == '0);

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs && bit_cnt != LAST) |=> bit_cnt == $past(bit_cnt) + CNT_W'(1));
endmodule

// File: rtl/tsa_channel.sv
// One channel's slot logic: burst decode, held transmit sample, receive shifter.
// Assumes: slot start = slot*8; the burst is 8 or 16 bits; a linear channel in the
// last slot is flagged and kept off both paths.
module tsa_channel #(
    parameter int SLOTS  = 32,
    parameter int SLOT_W = 5,
    parameter int CNT_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fs,
    input  logic [CNT_W-1:0]              bit_cnt,
    input  logic                          en,
    input  logic [SLOT_W-1:0]             slot,
    input  logic                          tx_a_sel,
    input  logic                          tx_b_sel,
    input  logic                          rx_b_sel,
    input  logic                          lin,
    input  logic                          cut,
    input  logic [tsa_pkg::SAMPLE_W-1:0]  sample,
    input  logic                          rx_a,
    input  logic                          rx_b,
    output logic                          own_a,
    output logic                          own_b,
    output logic                          claim_a,
    output logic                          claim_b,
    output logic                          tx_bit,
    output logic [CNT_W-1:0]              span_lo,
    output logic [CNT_W-1:0]              span_hi,
    output logic                          err,
    output logic [tsa_pkg::SAMPLE_W-1:0]  rx_data,
    output logic                          rx_valid
);
    import tsa_pkg::*;

    logic [SAMPLE_W-1:0] hold;
    logic [SAMPLE_W-1:0] shift;
    logic                active;
    logic                in_burst;
    logic                last_bit;
    logic                rx_bit;
    logic [CNT_W-1:0]    off;
    logic [3:0]          boff;

    // Configuration checks and the channel's bit range in the frame.
    assign err     = en & lin & (slot == SLOT_W'(SLOTS - 1));
    assign active  = en & ~err;
    assign span_lo = CNT_W'(slot) << 3;
    assign span_hi = span_lo + (lin ? CNT_W'(15) : CNT_W'(7));

    // Burst position decode.
    assign off      = bit_cnt - span_lo;
    assign boff     = off[3:0];
    assign in_burst = (bit_cnt >= span_lo) && (bit_cnt <= span_hi);
    assign last_bit = active & in_burst & (bit_cnt == span_hi);

    // Transmit ownership and the bit for this position, MSB first.
    assign own_a   = active & ~cut & tx_a_sel;
    assign own_b   = active & ~cut & tx_b_sel;
    assign claim_a = own_a & in_burst;
    assign claim_b = own_b & in_burst;
    assign tx_bit  = lin ? hold[~boff] : hold[{1'b0, ~boff[2:0]}];

    // Receive source choice.
    assign rx_bit = rx_b_sel ? rx_b : rx_a;

    // Capture the transmit sample at frame sync only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold <= '0;
        else if (fs)
            hold <= sample;
    end

    // Shift in receive bits during the burst and deliver after the final bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (active && in_burst) begin
                shift <= {shift[SAMPLE_W-2:0], rx_bit};
                if (last_bit) begin
                    rx_valid <= 1'b1;
                    rx_data  <= lin ? {shift[SAMPLE_W-2:0], rx_bit}
                                    : {8'h00, shift[6:0], rx_bit};
                end
            end
        end
    end

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fs |=> $stable(hold));

    // R6
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

// File: rtl/tsa_port_mux.sv
// Transmit port arbiter: picks the lowest-numbered claiming channel and flags
// overlapping ownership ranges among channels routed to the port.
// Assumes: claim/own come from tsa_channel; ranges are inclusive bit positions.
module tsa_port_mux #(
    parameter int NCH   = 4,
    parameter int CNT_W = 8
) (
    input  logic [NCH-1:0]            claim,
    input  logic [NCH-1:0]            bits,
    input  logic [NCH-1:0]            own,
    input  logic [NCH-1:0][CNT_W-1:0] lo,
    input  logic [NCH-1:0][CNT_W-1:0] hi,
    output logic                      d,
    output logic                      oe,
    output logic [NCH-1:0]            grant,
    output logic                      conflict
);
    logic [NCH*NCH-1:0] pair_hit;

    // Fixed priority: lowest index wins.
    always_comb begin
        grant = '0;
        for (int i = 0; i < NCH; i++)
            if (claim[i] && grant == '0)
                grant[i] = 1'b1;
    end

    assign oe = |claim;
    assign d  = |(grant & bits);

    // Pairwise overlap of ownership ranges.
    for (genvar gi = 0; gi < NCH; gi++) begin : g_row
        for (genvar gj = 0; gj < NCH; gj++) begin : g_col
            if (gj > gi) begin : g_pair
                assign pair_hit[gi*NCH+gj] = own[gi] & own[gj] &
                    (lo[gi] <= hi[gj]) & (lo[gj] <= hi[gi]);
            end else begin : g_none
                assign pair_hit[gi*NCH+gj] = 1'b0;
            end
        end
    end

    assign conflict = |pair_hit;
endmodule

// File: rtl/pcm_tsa.sv
// PCM time-slot assigner top: frame counter, one slot unit per channel, and
// an arbiter per transmit port.
// Assumes: clk is the PCM bit clock; SLOTS is a power of two; fs is one cycle wide.
module pcm_tsa #(
    parameter int NCH   = 4,
    parameter int SLOTS = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fs,
    input  logic [NCH-1:0]                cfg_en,
    input  logic [NCH*$clog2(SLOTS)-1:0]  cfg_slot,
    input  logic [NCH-1:0]                cfg_tx_a,
    input  logic [NCH-1:0]                cfg_tx_b,
    input  logic [NCH-1:0]                cfg_rx_b,
    input  logic [NCH-1:0]                cfg_lin,
    input  logic [NCH-1:0]                cfg_cut,
    input  logic [NCH*16-1:0]             tx_sample,
    input  logic                          rx_a,
    input  logic                          rx_b,
    output logic                          tx_a_d,
    output logic                          tx_a_oe,
    output logic                          tx_b_d,
    output logic                          tx_b_oe,
    output logic [NCH*16-1:0]             rx_data,
    output logic [NCH-1:0]                rx_valid,
    output logic [NCH-1:0]                cfg_err,
    output logic                          conflict_a,
    output logic                          conflict_b
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CNT_W  = $clog2(SLOTS * tsa_pkg::SLOT_BITS);
    localparam int SW     = tsa_pkg::SAMPLE_W;

    logic [CNT_W-1:0]            bit_cnt;
    logic [NCH-1:0]              own_a, own_b, claim_a, claim_b, tx_bit;
    logic [NCH-1:0]              grant_a, grant_b;
    logic [NCH-1:0][CNT_W-1:0]   span_lo, span_hi;

    tsa_frame_counter #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .fs(fs), .bit_cnt(bit_cnt)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        tsa_channel #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .fs       (fs),
            .bit_cnt  (bit_cnt),
            .en       (cfg_en[ch]),
            .slot     (cfg_slot[ch*SLOT_W +: SLOT_W]),
            .tx_a_sel (cfg_tx_a[ch]),
            .tx_b_sel (cfg_tx_b[ch]),
            .rx_b_sel (cfg_rx_b[ch]),
            .lin      (cfg_lin[ch]),
            .cut      (cfg_cut[ch]),
            .sample   (tx_sample[ch*SW +: SW]),
            .rx_a     (rx_a),
            .rx_b     (rx_b),
            .own_a    (own_a[ch]),
            .own_b    (own_b[ch]),
            .claim_a  (claim_a[ch]),
            .claim_b  (claim_b[ch]),
            .tx_bit   (tx_bit[ch]),
            .span_lo  (span_lo[ch]),
            .span_hi  (span_hi[ch]),
            .err      (cfg_err[ch]),
            .rx_data  (rx_data[ch*SW +: SW]),
            .rx_valid (rx_valid[ch])
        );

        // R4
        cut_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_cut[ch] |-> !grant_a[ch] && !grant_b[ch]);

        // R7
        err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_err[ch] |-> !grant_a[ch] && !grant_b[ch]);
    end

    tsa_port_mux #(.NCH(NCH), .CNT_W(CNT_W)) u_mux_a (
        .claim(claim_a), .bits(tx_bit), .own(own_a), .lo(span_lo), .hi(span_hi),
        .d(tx_a_d), .oe(tx_a_oe), .grant(grant_a), .conflict(conflict_a)
    );

    tsa_port_mux #(.NCH(NCH), .CNT_W(CNT_W)) u_mux_b (
        .claim(claim_b), .bits(tx_bit), .own(own_b), .lo(span_lo), .hi(span_hi),
        .d(tx_b_d), .oe(tx_b_oe), .grant(grant_b), .conflict(conflict_b)
    );

    // R8
    overlap_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(claim_a) > 1) |-> conflict_a);

    // R8
    overlap_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(claim_b) > 1) |-> conflict_b);
endmodule

// File: tb/pcm_tsa_tb.sv
module pcm_tsa_tb;
    localparam int NCH = 4;
    localparam int SLOTS = 32;
    localparam int SW = 5;
    localparam int FB = SLOTS * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fs = 1'b0;
    logic [NCH-1:0] cfg_en = '0, cfg_tx_a = '0, cfg_tx_b = '0, cfg_rx_b = '0, cfg_lin = '0, cfg_cut = '0;
    logic [NCH*SW-1:0] cfg_slot = '0;
    logic [NCH*16-1:0] tx_sample = '0;
    logic rx_a = 1'b0, rx_b = 1'b0;
    logic tx_a_d, tx_a_oe, tx_b_d, tx_b_oe, conflict_a, conflict_b;
    logic [NCH*16-1:0] rx_data;
    logic [NCH-1:0] rx_valid, cfg_err;

    int checks = 0;
    int errors = 0;
    bit fs_run = 0;
    bit started = 0;
    int tick = 0;

    // behavioural reference state
    int mcnt;
    logic [15:0] mhold [NCH];
    logic [15:0] mshift [NCH];
    logic [15:0] mrxd [NCH];
    logic mvalid [NCH];

    always #5 clk = ~clk;

    pcm_tsa #(.NCH(NCH), .SLOTS(SLOTS)) u_dut (
        .clk(clk), .rst_n(rst_n), .fs(fs), .cfg_en(cfg_en), .cfg_slot(cfg_slot),
        .cfg_tx_a(cfg_tx_a), .cfg_tx_b(cfg_tx_b), .cfg_rx_b(cfg_rx_b),
        .cfg_lin(cfg_lin), .cfg_cut(cfg_cut), .tx_sample(tx_sample),
        .rx_a(rx_a), .rx_b(rx_b), .tx_a_d(tx_a_d), .tx_a_oe(tx_a_oe),
        .tx_b_d(tx_b_d), .tx_b_oe(tx_b_oe), .rx_data(rx_data), .rx_valid(rx_valid),
        .cfg_err(cfg_err), .conflict_a(conflict_a), .conflict_b(conflict_b)
    );

    function automatic int slot_of(int c);
        return int'(cfg_slot[c*SW +: SW]);
    endfunction
    function automatic bit m_err(int c);
        return cfg_en[c] && cfg_lin[c] && slot_of(c) == SLOTS - 1;
    endfunction
    function automatic bit m_active(int c);
        return cfg_en[c] && !m_err(c);
    endfunction
    function automatic int m_len(int c);
        return cfg_lin[c] ? 16 : 8;
    endfunction
    function automatic bit m_in(int c);
        return mcnt >= slot_of(c) * 8 && mcnt < slot_of(c) * 8 + m_len(c);
    endfunction
    function automatic bit m_owns(int c, bit port_b);
        return m_active(c) && !cfg_cut[c] && (port_b ? cfg_tx_b[c] : cfg_tx_a[c]);
    endfunction

    // expected {oe, d} for a port, lowest channel first
    function automatic logic [1:0] m_port(bit port_b);
        for (int c = 0; c < NCH; c++) begin
            if (m_owns(c, port_b) && m_in(c))
                return {1'b1, mhold[c][m_len(c) - 1 - (mcnt - slot_of(c) * 8)]};
        end
        return 2'b00;
    endfunction

    function automatic bit m_conflict(bit port_b);
        for (int i = 0; i < NCH; i++)
            for (int j = i + 1; j < NCH; j++)
                if (m_owns(i, port_b) && m_owns(j, port_b) &&
                    slot_of(i) * 8 <= slot_of(j) * 8 + m_len(j) - 1 &&
                    slot_of(j) * 8 <= slot_of(i) * 8 + m_len(i) - 1)
                    return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance the reference model at every rising edge.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            mcnt = 0;
            for (int c = 0; c < NCH; c++) begin
                mhold[c] = '0; mshift[c] = '0; mrxd[c] = '0; mvalid[c] = 1'b0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                logic b;
                mvalid[c] = 1'b0;
                b = cfg_rx_b[c] ? rx_b : rx_a;
                if (m_active(c) && m_in(c)) begin
                    if (mcnt == slot_of(c) * 8 + m_len(c) - 1) begin
                        mvalid[c] = 1'b1;
                        mrxd[c] = cfg_lin[c] ? {mshift[c][14:0], b} : {8'h00, mshift[c][6:0], b};
                    end
                    mshift[c] = {mshift[c][14:0], b};
                end
            end
            if (fs) begin
                for (int c = 0; c < NCH; c++) mhold[c] = tx_sample[c*16 +: 16];
                mcnt = 0;
            end else begin
                mcnt = (mcnt + 1) % FB;
            end
        end
    end

    // Compare every output with the model at each falling edge.
    always @(negedge clk) begin
        if (started) begin
            logic [1:0] ea, eb;
            ea = m_port(1'b0);
            eb = m_port(1'b1);
            chk("R1 R4 tx_a_oe", 32'(tx_a_oe), 32'(ea[1]));
            chk("R2 R5 tx_a_d", 32'(tx_a_d), 32'(ea[0]));
            chk("R3 R4 tx_b_oe", 32'(tx_b_oe), 32'(eb[1]));
            chk("R3 R5 tx_b_d", 32'(tx_b_d), 32'(eb[0]));
            chk("R8 conflict_a", 32'(conflict_a), 32'(m_conflict(1'b0)));
            chk("R8 conflict_b", 32'(conflict_b), 32'(m_conflict(1'b1)));
            for (int c = 0; c < NCH; c++) begin
                chk("R6 rx_valid", 32'(rx_valid[c]), 32'(mvalid[c]));
                chk("R6 rx_data", 32'(rx_data[c*16 +: 16]), 32'(mrxd[c]));
                chk("R7 cfg_err", 32'(cfg_err[c]), 32'(m_err(c)));
            end
        end
    end

    // Per-cycle stimulus: frame sync, random receive lines and samples.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            fs = fs_run && tick == 0;
            tick = (tick + 1) % FB;
            rx_a = 1'($urandom);
            rx_b = 1'($urandom);
            for (int c = 0; c < NCH; c++) tx_sample[c*16 +: 16] = 16'($urandom);
        end
    end

    task automatic set_ch(input int c, input bit en, input int slot, input bit ta,
                          input bit tb, input bit rb, input bit lin, input bit cut);
        cfg_en[c] = en; cfg_slot[c*SW +: SW] = SW'(slot);
        cfg_tx_a[c] = ta; cfg_tx_b[c] = tb; cfg_rx_b[c] = rb;
        cfg_lin[c] = lin; cfg_cut[c] = cut;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        wait_cycles(3);
        // R9 reset state
        chk("R9 tx_a_oe after reset", 32'(tx_a_oe), 0);
        chk("R9 tx_b_oe after reset", 32'(tx_b_oe), 0);
        chk("R9 rx_valid after reset", 32'(rx_valid), 0);
        chk("R9 rx_data after reset", 32'(rx_data[31:0]), 0);
        rst_n = 1'b1;
        // free-running frames before sync (R1 wrap), then normal traffic
        set_ch(0, 1, 2, 1, 0, 0, 0, 0);
        set_ch(1, 1, 5, 0, 1, 1, 1, 0);
        set_ch(2, 1, 10, 1, 1, 0, 0, 0);
        set_ch(3, 1, 20, 1, 0, 1, 1, 1);
        wait_cycles(FB + 37);
        fs_run = 1;
        wait_cycles(3 * FB);
        // R8 overlap on port A: ch3 linear on slots 1-2 against ch0 on slot 2
        set_ch(3, 1, 1, 1, 0, 1, 1, 0);
        wait_cycles(2 * FB);
        // R7 linear channel in last slot, R4 disabled channel
        set_ch(1, 1, SLOTS - 1, 1, 1, 1, 1, 0);
        set_ch(2, 0, 10, 1, 1, 0, 0, 0);
        set_ch(3, 1, 30, 0, 1, 0, 0, 0);
        wait_cycles(2 * FB);
        // R4 everything cut off, receive still running
        cfg_cut = '1;
        wait_cycles(FB);
        finish_run();
    end
endmodule